// File: doc/BRIEF.md
# Dual-Channel Memory Address Steering

This block sits between a request source and two independent memory channels. Each cycle it can take up to two physical memory requests, one per input lane. For each request it picks the channel that owns the address and works out the address as that channel sees it. It then presents the request on that channel's valid/ready output. The channel controllers downstream handle everything after that, including command timing, rank and bank selection, and data movement.

A configuration input picks one of two ways of organizing memory, and gives the populated capacity of each channel in units of 64-byte cache lines.

- **Interleaved mode:** consecutive cache lines alternate between the channels, so a pair of neighbouring lines can go out on both channels together. This mode needs both channels to hold the same capacity. If they do not, the configuration is reported invalid.
- **Asymmetric mode:** the low part of the address space fills channel A and the rest continues into channel B. Any population is allowed, including an empty channel.

A request that falls outside the populated space is not forwarded. It is completed with an error pulse instead. The configuration is latched only while nothing is in flight.

Top module: `mem_chan_steer`

## Requirements
- R1: After reset both channel outputs are invalid, `req_ready` is high, `req_err` is zero and `cfg_err` is low.
- R2: In interleaved mode, address bit 6 selects the channel (0 gives channel A, 1 gives channel B). The channel address is the request address with bit 6 removed: bits above 6 move down by one, bits 5..0 are kept, and the top bit is zero.
- R3: In interleaved mode with unequal capacities, `cfg_err` is high and every accepted request ends with an error pulse instead of a dispatch.
- R4: In asymmetric mode, a request whose line index (address bits 19..6) is below channel A's capacity goes to channel A with an unchanged address. Any other in-range request goes to channel B with the address minus 64 times channel A's capacity.
- R5: In asymmetric mode, a capacity of zero on either channel is a valid configuration (`cfg_err` low), and all requests map to the populated channel.
- R6: A request whose line index is at or above the sum of both capacities raises its lane's `req_err` bit in the cycle it is accepted and is never presented on a channel.
- R7: When both lanes carry valid in-range requests for different channels, both channel outputs are valid in the cycle after acceptance.
- R8: When both lanes target the same channel, lane 0 is presented first. Lane 1 follows in the cycle after lane 0's handshake, and `req_ready` stays low while lane 1 waits.
- R9: A channel output whose ready is low keeps valid, address and write flag unchanged into the next cycle.
- R10: A configuration change while a request is outstanding has no effect (`cfg_err` and the mapping keep their old values). The configuration is latched at the end of every cycle in which nothing is outstanding, and applies to requests accepted after that edge.
- R11: `req_ready` is high only when no lane-1 request is waiting and each channel output is either empty or completing its handshake in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_asym | input | 1 | 0 = interleaved, 1 = asymmetric |
| cfg_cap_a | input | 14 | Channel A capacity in cache lines |
| cfg_cap_b | input | 14 | Channel B capacity in cache lines |
| cfg_err | output | 1 | Latched configuration is invalid |
| req_valid | input | 2 | Per-lane request valid |
| req_addr0 | input | 20 | Lane 0 byte address |
| req_addr1 | input | 20 | Lane 1 byte address |
| req_we | input | 2 | Per-lane write flag |
| req_ready | output | 1 | Both lanes are accepted this cycle |
| req_err | output | 2 | Per-lane range/config error pulse on acceptance |
| a_valid | output | 1 | Channel A request valid |
| a_addr | output | 20 | Channel A local address |
| a_we | output | 1 | Channel A write flag |
| a_ready | input | 1 | Channel A accepts |
| b_valid | output | 1 | Channel B request valid |
| b_addr | output | 20 | Channel B local address |
| b_we | output | 1 | Channel B write flag |
| b_ready | input | 1 | Channel B accepts |

## Verification
Some properties are checked on every cycle:
- a stalled channel output holds steady;
- a channel register is loaded only when it is free;
- the latched configuration stays put while anything is outstanding;
- a waiting lane-1 request always sits behind a busy output on its channel;
- a split pair lights both channels together.

Other behaviours only the bench scenarios can show:
- the address arithmetic of both modes;
- the exact set of out-of-range errors;
- the lane ordering seen through the handshakes;
- the delayed effect of a configuration change.

The bench checks these against a scoreboard under random backpressure.

// File: rtl/mcs_pkg.sv
package mcs_pkg;
    localparam int ADDR_W = 20;              // byte address width
    localparam int LINE_B = 6;               // log2 of the cache-line size
    localparam int LINE_W = ADDR_W - LINE_B; // line index width
    localparam int NLANE  = 2;               // request lanes per cycle
    localparam int NCH    = 2;               // memory channels

    localparam logic CH_A = 1'b0;
    localparam logic CH_B = 1'b1;

    typedef enum logic {
        MODE_ILV  = 1'b0,
        MODE_ASYM = 1'b1
    } mode_e;

    typedef struct packed {
        mode_e              mode;
        logic [LINE_W-1:0]  cap_a;
        logic [LINE_W-1:0]  cap_b;
    } cfg_t;

    typedef struct packed {
        logic               chan;
        logic [ADDR_W-1:0]  addr;
        logic               we;
    } cmd_t;

    // Interleaving needs matching populations; the linear mode takes anything.
    function automatic logic cfg_ok(input cfg_t c);
        return (c.mode == MODE_ASYM) || (c.cap_a == c.cap_b);
    endfunction
endpackage

// File: rtl/mcs_decode.sv
module mcs_decode
    import mcs_pkg::*;
(
    input  cfg_t              cfg,
    input  logic [ADDR_W-1:0] addr,
    input  logic              we,
    output cmd_t              cmd,
    output logic              bad
);
    logic [LINE_W-1:0] line;
    logic [LINE_W:0]   total;
    logic              in_a;

    assign line  = addr[ADDR_W-1:LINE_B];
    assign total = {1'b0, cfg.cap_a} + {1'b0, cfg.cap_b};
    assign in_a  = line < cfg.cap_a;
    assign bad   = !cfg_ok(cfg) || ({1'b0, line} >= total);

    always_comb begin
        cmd.we = we;
        if (cfg.mode == MODE_ILV) begin
            cmd.chan = addr[LINE_B];
            cmd.addr = {1'b0, addr[ADDR_W-1:LINE_B+1], addr[LINE_B-1:0]};
        end else begin
            cmd.chan = in_a ? CH_A : CH_B;
            cmd.addr = in_a ? addr : addr - {cfg.cap_a, {LINE_B{1'b0}}};
        end
    end
endmodule

// File: rtl/mcs_chan_out.sv
module mcs_chan_out
    import mcs_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic [ADDR_W-1:0] ld_addr,
    input  logic              ld_we,
    input  logic              ready,
    output logic              valid,
    output logic [ADDR_W-1:0] addr,
    output logic              we,
    output logic              free
);
    assign free = !valid || ready;

    always_ff @(posedge clk) begin
        if (rst) begin
            valid <= 1'b0;
            addr  <= '0;
            we    <= 1'b0;
        end else if (load) begin
            valid <= 1'b1;
            addr  <= ld_addr;
            we    <= ld_we;
        end else if (ready) begin
            valid <= 1'b0;
        end
    end

    // R9: a stalled request keeps its contents
    p_hold_stable_r9: assert property (@(posedge clk) disable iff (rst)
        (valid && !ready) |=> (valid && $stable(addr) && $stable(we)));

    // R11: the register is only reloaded once its current content is gone
    p_load_free_r11: assert property (@(posedge clk) disable iff (rst)
        load |-> (!valid || ready));
endmodule

// File: rtl/mem_chan_steer.sv
module mem_chan_steer
    import mcs_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_asym,
    input  logic [LINE_W-1:0] cfg_cap_a,
    input  logic [LINE_W-1:0] cfg_cap_b,
    output logic              cfg_err,
    input  logic [NLANE-1:0]  req_valid,
    input  logic [ADDR_W-1:0] req_addr0,
    input  logic [ADDR_W-1:0] req_addr1,
    input  logic [NLANE-1:0]  req_we,
    output logic              req_ready,
    output logic [NLANE-1:0]  req_err,
    output logic              a_valid,
    output logic [ADDR_W-1:0] a_addr,
    output logic              a_we,
    input  logic              a_ready,
    output logic              b_valid,
    output logic [ADDR_W-1:0] b_addr,
    output logic              b_we,
    input  logic              b_ready
);
    cfg_t              cfg_q;
    logic [ADDR_W-1:0] lane_addr [NLANE];
    cmd_t              lane_cmd  [NLANE];
    logic [NLANE-1:0]  lane_bad;
    logic [NLANE-1:0]  take;
    logic              collide;
    cmd_t              wait_q;
    logic              wait_v;
    logic              idle;

    logic [NCH-1:0]    ch_v, ch_we, ch_free, ch_rdy;
    logic [ADDR_W-1:0] ch_addr [NCH];

    assign lane_addr[0] = req_addr0;
    assign lane_addr[1] = req_addr1;
    assign ch_rdy       = {b_ready, a_ready};

    // ---------------- configuration latch ----------------
    assign idle = !wait_v && (ch_v == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q <= '{mode: MODE_ILV, cap_a: '0, cap_b: '0};
        end else if (idle) begin
            cfg_q <= '{mode: (cfg_asym ? MODE_ASYM : MODE_ILV),
                       cap_a: cfg_cap_a, cap_b: cfg_cap_b};
        end
    end

    assign cfg_err = !cfg_ok(cfg_q);

    // ---------------- per-lane decode ----------------
    for (genvar g = 0; g < NLANE; g++) begin : g_lane
        mcs_decode u_dec (
            .cfg  (cfg_q),
            .addr (lane_addr[g]),
            .we   (req_we[g]),
            .cmd  (lane_cmd[g]),
            .bad  (lane_bad[g])
        );
        assign take[g]    = req_ready && req_valid[g] && !lane_bad[g];
        assign req_err[g] = req_ready && req_valid[g] &&  lane_bad[g];
    end

    assign req_ready = !wait_v && (&ch_free);
    assign collide   = take[0] && take[1] && (lane_cmd[0].chan == lane_cmd[1].chan);

    // ---------------- lane-1 parking slot ----------------
    always_ff @(posedge clk) begin
        if (rst) begin
            wait_v <= 1'b0;
            wait_q <= '0;
        end else if (collide) begin
            wait_v <= 1'b1;
            wait_q <= lane_cmd[1];
        end else if (wait_v && ch_free[wait_q.chan]) begin
            wait_v <= 1'b0;
        end
    end

    // ---------------- per-channel output ----------------
    for (genvar c = 0; c < NCH; c++) begin : g_ch
        logic ld;
        cmd_t ld_cmd;

        always_comb begin
            ld     = 1'b0;
            ld_cmd = lane_cmd[0];
            if (take[0] && lane_cmd[0].chan == 1'(c)) begin
                ld = 1'b1;
            end else if (take[1] && lane_cmd[1].chan == 1'(c)) begin
                ld     = 1'b1;
                ld_cmd = lane_cmd[1];
            end else if (wait_v && wait_q.chan == 1'(c) && ch_free[c]) begin
                ld     = 1'b1;
                ld_cmd = wait_q;
            end
        end

        mcs_chan_out u_out (
            .clk     (clk),
            .rst     (rst),
            .load    (ld),
            .ld_addr (ld_cmd.addr),
            .ld_we   (ld_cmd.we),
            .ready   (ch_rdy[c]),
            .valid   (ch_v[c]),
            .addr    (ch_addr[c]),
            .we      (ch_we[c]),
            .free    (ch_free[c])
        );
    end

    assign a_valid = ch_v[0];
    assign a_addr  = ch_addr[0];
    assign a_we    = ch_we[0];
    assign b_valid = ch_v[1];
    assign b_addr  = ch_addr[1];
    assign b_we    = ch_we[1];

    // R10: configuration frozen while anything is in flight
    p_cfg_frozen_r10: assert property (@(posedge clk) disable iff (rst)
        !idle |=> $stable(cfg_q));

    // R8: a parked lane-1 request always sits behind an occupied channel
    p_wait_behind_r8: assert property (@(posedge clk) disable iff (rst)
        wait_v |-> ch_v[wait_q.chan]);

    // R7: a split pair appears on both channels together
    p_split_pair_r7: assert property (@(posedge clk) disable iff (rst)
        (take[0] && take[1] && lane_cmd[0].chan != lane_cmd[1].chan)
            |=> (a_valid && b_valid));
endmodule

// File: tb/mem_chan_steer_tb.sv
module mem_chan_steer_tb;
    logic        clk = 1'b0;
    logic        rst;
    logic        cfg_asym;
    logic [13:0] cfg_cap_a, cfg_cap_b;
    logic        cfg_err;
    logic [1:0]  req_valid;
    logic [19:0] req_addr0, req_addr1;
    logic [1:0]  req_we;
    logic        req_ready;
    logic [1:0]  req_err;
    logic        a_valid, a_we, a_ready;
    logic [19:0] a_addr;
    logic        b_valid, b_we, b_ready;
    logic [19:0] b_addr;

    int checks = 0;
    int fails  = 0;
    int rdy_mode = 1;          // 0 random, 1 always high, 2 always low
    int m_mode, m_ca, m_cb;    // model copy of the latched configuration
    logic [20:0] qa[$];
    logic [20:0] qb[$];
    bit          held [2];
    logic [19:0] hold_addr [2];
    logic        hold_we [2];

    always #10 clk = ~clk;     // 50 MHz

    mem_chan_steer u_dut (
        .clk(clk), .rst(rst),
        .cfg_asym(cfg_asym), .cfg_cap_a(cfg_cap_a), .cfg_cap_b(cfg_cap_b), .cfg_err(cfg_err),
        .req_valid(req_valid), .req_addr0(req_addr0), .req_addr1(req_addr1),
        .req_we(req_we), .req_ready(req_ready), .req_err(req_err),
        .a_valid(a_valid), .a_addr(a_addr), .a_we(a_we), .a_ready(a_ready),
        .b_valid(b_valid), .b_addr(b_addr), .b_we(b_we), .b_ready(b_ready)
    );

    // ---------------- reference model ----------------
    function automatic bit m_bad(int a);
        if (m_mode == 0 && m_ca != m_cb) return 1'b1;
        return (a >> 6) >= (m_ca + m_cb);
    endfunction

    function automatic bit m_chan(int a);
        if (m_mode == 0) return a[6];
        return (a >> 6) >= m_ca;
    endfunction

    function automatic int m_loc(int a);
        if (m_mode == 0) return ((a >> 7) << 6) | (a & 63);
        return m_chan(a) ? a - m_ca * 64 : a;
    endfunction

    task automatic chk(bit ok, string req, int act, int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h t=%0t", req, act, exp, $time);
        end
    endtask

    task automatic report;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    endtask

    // ---------------- ready generation ----------------
    always @(negedge clk) begin
        a_ready <= (rdy_mode == 1) ? 1'b1 : (rdy_mode == 2) ? 1'b0 : ($urandom % 3 != 0);
        b_ready <= (rdy_mode == 1) ? 1'b1 : (rdy_mode == 2) ? 1'b0 : ($urandom % 3 != 0);
    end

    // ---------------- channel monitor ----------------
    task automatic mon(int c, logic v, logic [19:0] ad, logic w, logic r);
        logic [20:0] e;
        if (held[c])
            chk(v && ad == hold_addr[c] && w == hold_we[c], "R9 hold", {11'b0, v, ad}, {12'b1, hold_addr[c]});
        if (v && r) begin
            held[c] = 1'b0;
            if ((c == 0 ? qa.size() : qb.size()) == 0) begin
                chk(1'b0, "R6 unexpected dispatch", {11'b0, w, ad}, 0);
            end else begin
                e = (c == 0) ? qa.pop_front() : qb.pop_front();
                chk({w, ad} == e, "R2/R4/R8 channel content", {11'b0, w, ad}, {11'b0, e});
            end
        end else if (v) begin
            held[c]      = 1'b1;
            hold_addr[c] = ad;
            hold_we[c]   = w;
        end else begin
            held[c] = 1'b0;
        end
    endtask

    always begin
        @(negedge clk);
        #8;
        if (!rst) begin
            mon(0, a_valid, a_addr, a_we, a_ready);
            mon(1, b_valid, b_addr, b_we, b_ready);
        end
    end

    // ---------------- stimulus tasks ----------------
    task automatic issue(bit v0, int a0, bit w0, bit v1, int a1, bit w1);
        @(negedge clk); #2;
        while (!req_ready) begin @(negedge clk); #2; end
        req_valid = {v1, v0};
        req_addr0 = a0[19:0];
        req_addr1 = a1[19:0];
        req_we    = {w1, w0};
        #1;
        chk(req_err[0] == (v0 && m_bad(a0)), "R6/R3 lane0 error", int'(req_err[0]), int'(v0 && m_bad(a0)));
        chk(req_err[1] == (v1 && m_bad(a1)), "R6/R3 lane1 error", int'(req_err[1]), int'(v1 && m_bad(a1)));
        if (v0 && !m_bad(a0)) begin
            if (m_chan(a0)) qb.push_back({w0, 20'(m_loc(a0))});
            else            qa.push_back({w0, 20'(m_loc(a0))});
        end
        if (v1 && !m_bad(a1)) begin
            if (m_chan(a1)) qb.push_back({w1, 20'(m_loc(a1))});
            else            qa.push_back({w1, 20'(m_loc(a1))});
        end
        @(posedge clk); #1;
        req_valid = 2'b00;
    endtask

    task automatic drain;
        rdy_mode = 1;
        while (qa.size() != 0 || qb.size() != 0) @(negedge clk);
        repeat (2) @(negedge clk);
    endtask

    task automatic set_cfg(int mode, int ca, int cb);
        drain();
        cfg_asym  = mode[0];
        cfg_cap_a = 14'(ca);
        cfg_cap_b = 14'(cb);
        m_mode = mode; m_ca = ca; m_cb = cb;
        repeat (2) @(negedge clk);
    endtask

    // ---------------- watchdog ----------------
    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog actual=timeout expected=completion");
        report();
    end

    // ---------------- main sequence ----------------
    initial begin
        void'($urandom(32'h5eed_0042));
        rst = 1'b1;
        req_valid = 2'b00; req_addr0 = '0; req_addr1 = '0; req_we = 2'b00;
        cfg_asym = 1'b0; cfg_cap_a = '0; cfg_cap_b = '0;
        m_mode = 0; m_ca = 0; m_cb = 0;
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        @(negedge clk); #8;
        // R1 reset state
        chk(!a_valid && !b_valid, "R1 outputs idle", {a_valid, b_valid}, 0);
        chk(req_ready && req_err == 2'b00, "R1 ready/err", {req_ready, req_err}, 4);
        chk(!cfg_err, "R1 cfg_err", int'(cfg_err), 0);

        // R7 split pair, interleaved 16/16
        set_cfg(0, 16, 16);
        issue(1, 'h000, 0, 1, 'h040, 1);
        @(negedge clk); #8;
        chk(a_valid && b_valid, "R7 both channels", {a_valid, b_valid}, 3);

        // R8 same-channel pair
        issue(1, 'h000, 0, 1, 'h080, 0);
        @(negedge clk); #8;
        chk(a_valid && a_addr == 0 && !req_ready, "R8 lane0 first", {req_ready, a_valid, a_addr}, 'h100000);
        @(negedge clk); #8;
        chk(a_valid && a_addr == 'h40, "R8 lane1 follows", {a_valid, a_addr}, 'h100040);

        // R2 bit-6 removal
        issue(1, 'h3C5, 1, 0, 0, 0);
        @(negedge clk); #8;
        chk(b_valid && b_addr == 'h1C5 && b_we, "R2 local address", {b_valid, b_addr}, 'h1001C5);

        // R3 unequal interleave
        set_cfg(0, 16, 8);
        chk(cfg_err, "R3 cfg_err", int'(cfg_err), 1);
        issue(1, 'h000, 0, 1, 'h040, 0);

        // R5 single-channel cases
        set_cfg(1, 0, 8);
        chk(!cfg_err, "R5 empty A legal", int'(cfg_err), 0);
        issue(1, 'h010, 0, 1, 'h1FF, 1);
        issue(1, 'h200, 0, 0, 0, 0);
        set_cfg(1, 8, 0);
        chk(!cfg_err, "R5 empty B legal", int'(cfg_err), 0);
        issue(1, 'h1C0, 1, 1, 'h200, 0);

        // R4 boundary between channels
        set_cfg(1, 5, 9);
        issue(1, 'h13F, 0, 1, 'h140, 1);
        @(negedge clk); #8;
        chk(a_valid && a_addr == 'h13F, "R4 below boundary", {a_valid, a_addr}, 'h10013F);
        chk(b_valid && b_addr == 'h000, "R4 above boundary", {b_valid, b_addr}, 'h100000);

        // R9 / R10 / R11 with channel A stalled
        set_cfg(0, 16, 16);
        rdy_mode = 2;
        issue(1, 'h000, 1, 0, 0, 0);
        cfg_cap_b = 14'd8;
        repeat (3) begin
            @(negedge clk); #8;
            chk(a_valid && a_addr == 0 && a_we, "R9 stalled output", {a_valid, a_addr}, 'h100000);
            chk(!req_ready, "R11 ready low while stalled", int'(req_ready), 0);
            chk(!cfg_err, "R10 config ignored while busy", int'(cfg_err), 0);
        end
        drain();
        m_cb = 8;
        @(negedge clk); #8;
        chk(cfg_err, "R10 config taken when idle", int'(cfg_err), 1);
        chk(req_ready, "R11 ready when idle", int'(req_ready), 1);

        // constrained random
        for (int k = 0; k < 40; k++) begin
            int md, ca, cb, lim;
            md = $urandom % 2;
            ca = $urandom % 17;
            cb = (md == 0 && ($urandom % 5) != 0) ? ca : $urandom % 17;
            set_cfg(md, ca, cb);
            lim = (ca + cb + 2) * 64;
            rdy_mode = 0;
            for (int j = 0; j < 12; j++) begin
                issue(1'($urandom % 4 != 0), $urandom % lim, 1'($urandom),
                      1'($urandom % 4 != 0), $urandom % lim, 1'($urandom));
            end
        end
        drain();
        chk(qa.size() == 0 && qb.size() == 0, "R6/R8 all expected dispatched", qa.size() + qb.size(), 0);
        report();
    end
endmodule